// File: doc/BRIEF.md
# Set-Pinned Shared Cache Controller with Per-Processor Overflow

This block holds the tag and control state of a last-level cache shared by several processors. Each set of the main array carries an owner field: a processor identifier plus an "owned" flag. Next to the main array sits one small fully associative overflow cache per processor. A request carries an address and the requesting processor's identifier. It is looked up in the indexed set and, at the same time, in every overflow cache. The response gives hit or miss. On a hit it tells where the line was found. On a miss it tells which structure and which slot will receive the line.

Only the owner of a set may evict from it. A miss to an unowned set claims the set for the requester. A miss to a set the requester owns replaces the least recently used way. A miss to a set owned by some other processor leaves the main array untouched. The line goes instead into the requester's own overflow cache, displacing that cache's least recently used entry. The data transfer from memory is reduced to a fill acknowledgement. A separate block may drop a set's ownership through an owner-clear input. Only tags, valid bits, owners and age state are stored; no data is kept.

Top module: `setpin_llc`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, every set is unowned, and every main and overflow entry is invalid. The first access to any set therefore misses and is placed in main way 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1, and `req_ready` is 1 only while the block is idle. `rsp_valid` is 1 for exactly the cycle after acceptance. After a miss, `req_ready` stays 0 until the cycle after `fill_ack` is seen.
- R3: The address is split into a set index (its low log2(sets) bits) and a tag (the remaining bits). A tag match in the indexed set gives `rsp_hit`=1, `rsp_src`=2'b01 (main) and `rsp_slot`= the matching way, whichever processor asks. `rsp_bank` then equals the requester.
- R4: All overflow caches are searched alongside the main set, each comparing the full address. A main miss that matches any overflow cache gives `rsp_hit`=1 and `rsp_src`=2'b10 (overflow). `rsp_slot` is the matching entry and `rsp_bank` is the processor that owns that overflow cache.
- R5: `rsp_hit`=0 only when neither the indexed set nor any overflow cache holds the address. No address is ever held in two places.
- R6: A miss to an unowned set reports `rsp_src`=2'b01 with the set's least recently used way. On `fill_ack` the line is installed there and the requester becomes the set's owner.
- R7: A miss to a set owned by the requester reports `rsp_src`=2'b01 and evicts the set's least recently used way. Ages are updated by hits and fills.
- R8: A miss to a set owned by another processor reports `rsp_src`=2'b10 with `rsp_bank` = the requester. The main set's lines and owner stay unchanged.
- R9: Overflow fills go into the requester's overflow entry with the oldest age. Hits in an overflow cache make the matching entry the youngest.
- R10: A pulse on `own_clr_valid` with set `own_clr_set` makes that set unowned, and its lines stay valid. The next miss to the set, from any processor, claims it.
- R11: `fill_ack` has no effect unless the block is waiting for a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Line address: low bits are the set index, high bits the tag |
| req_pid | input | PID_W | Requesting processor |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | 1 on a hit |
| rsp_src | output | 2 | 2'b01 main array, 2'b10 overflow cache |
| rsp_slot | output | SLOT_W | Way or overflow entry that hit or will be filled |
| rsp_bank | output | PID_W | Overflow cache involved, or the requester for main accesses |
| fill_ack | input | 1 | Memory has returned the missed line |
| own_clr_valid | input | 1 | Drop ownership of one set |
| own_clr_set | input | IDX_W | Set whose ownership is dropped |

## Verification
The assertions assume the environment raises `fill_ack` only after a miss response and keeps a single request in flight, which the handshake enforces. They also assume that ownership changes only through fills and the owner-clear input. Under these conditions an address can never sit in two structures, and a set owned by another processor is never filled. The stimulus acknowledges every fill exactly once. It issues owner clears only while the block is idle, and it pulses `fill_ack` in the idle state only to show that the pulse is ignored.

// File: rtl/setpin_pkg.sv
package setpin_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'b00,
      SRC_MAIN = 2'b01,
      SRC_OVF  = 2'b10
   } src_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOOK,
      ST_WAIT
   } state_e;
endpackage

// File: rtl/setpin_age_lru.sv
// True-LRU age ranking for one group of slots; oldest slot is the victim.
module setpin_age_lru #(
   parameter  int WAYS = 4,
   localparam int IW   = $clog2(WAYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [IW-1:0] touch_idx,
   output logic [IW-1:0] victim
);
   generate
      if (WAYS < 2) begin : g_bad
         $error("setpin_age_lru: WAYS must be at least 2");
      end
   endgenerate

   logic [IW-1:0]   age [WAYS];
   logic [WAYS-1:0] oldest;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++) age[w] <= IW'(WAYS - 1 - w);
      end else if (touch) begin
         for (int w = 0; w < WAYS; w++) begin
            if (IW'(w) == touch_idx)           age[w] <= '0;
            else if (age[w] < age[touch_idx])  age[w] <= age[w] + 1'b1;
         end
      end
   end

   always_comb begin
      victim = '0;
      for (int w = 0; w < WAYS; w++) begin
         oldest[w] = (age[w] == IW'(WAYS - 1));
         if (oldest[w]) victim = IW'(w);
      end
   end

   // R7 / R9: ages stay a permutation, so exactly one slot is oldest
   p_single_oldest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(oldest));
endmodule

// File: rtl/setpin_ovf_bank.sv
// One processor's small fully associative overflow cache.
module setpin_ovf_bank #(
   parameter  int ENTRIES = 4,
   parameter  int AW      = 12,
   localparam int EW      = $clog2(ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] lk_addr,
   output logic          hit,
   output logic [EW-1:0] hit_idx,
   input  logic          upd_hit,
   input  logic          fill,
   output logic [EW-1:0] victim
);
   logic [AW-1:0]      addr_q [ENTRIES];
   logic [ENTRIES-1:0] vld_q;

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (vld_q[e] && addr_q[e] == lk_addr && !hit) begin
            hit     = 1'b1;
            hit_idx = EW'(e);
         end
      end
   end

   setpin_age_lru #(.WAYS(ENTRIES)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (upd_hit | fill),
      .touch_idx (fill ? victim : hit_idx),
      .victim    (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    vld_q         <= '0;
      else if (fill) vld_q[victim] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill) addr_q[victim] <= lk_addr;
   end

   // R9: a fill installs the address in the slot the ranking chose
   p_fill_installs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill |=> vld_q[$past(victim)] && addr_q[$past(victim)] == $past(lk_addr));
endmodule

// File: rtl/setpin_main_array.sv
// Set-associative main tag array with per-set owner field.
module setpin_main_array #(
   parameter  int SETS  = 16,
   parameter  int WAYS  = 4,
   parameter  int TAG_W = 8,
   parameter  int NPROC = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int PID_W = $clog2(NPROC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [PID_W-1:0] lk_pid,
   output logic             hit,
   output logic [WAY_W-1:0] hit_way,
   output logic [WAY_W-1:0] victim,
   output logic             owned,
   output logic [PID_W-1:0] owner,
   input  logic             upd_hit,
   input  logic             fill,
   input  logic             clr_valid,
   input  logic [IDX_W-1:0] clr_idx
);
   logic [TAG_W-1:0] tag_q  [SETS][WAYS];
   logic [WAYS-1:0]  vld_q  [SETS];
   logic [SETS-1:0]  own_v;
   logic [PID_W-1:0] own_id [SETS];
   logic [WAY_W-1:0] set_vic [SETS];

   generate
      for (genvar s = 0; s < SETS; s++) begin : g_set
         setpin_age_lru #(.WAYS(WAYS)) u_age (
            .clk       (clk),
            .rst_n     (rst_n),
            .touch     ((upd_hit | fill) && lk_idx == IDX_W'(s)),
            .touch_idx (fill ? set_vic[s] : hit_way),
            .victim    (set_vic[s])
         );
      end
   endgenerate

   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (vld_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag && !hit) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
      victim = set_vic[lk_idx];
      owned  = own_v[lk_idx];
      owner  = own_id[lk_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_v <= '0;
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else begin
         if (fill) begin
            vld_q[lk_idx][victim] <= 1'b1;
            if (!own_v[lk_idx]) own_v[lk_idx] <= 1'b1;
         end
         if (clr_valid) own_v[clr_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (fill) begin
         tag_q[lk_idx][victim] <= lk_tag;
         if (!own_v[lk_idx]) own_id[lk_idx] <= lk_pid;
      end
   end

   // R8: a set held by another processor never receives a fill
   p_no_foreign_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill && own_v[lk_idx] |-> own_id[lk_idx] == lk_pid);

   // R6: a fill into an unowned set hands it to the requester
   p_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fill && !own_v[lk_idx] && !(clr_valid && clr_idx == lk_idx)
      |=> own_v[$past(lk_idx)] && own_id[$past(lk_idx)] == $past(lk_pid));
endmodule

// File: rtl/setpin_llc.sv
module setpin_llc
   import setpin_pkg::*;
#(
   parameter  int NPROC  = 4,
   parameter  int NSETS  = 16,
   parameter  int NWAYS  = 4,
   parameter  int NOVF   = 4,
   parameter  int ADDR_W = 12,
   localparam int PID_W  = $clog2(NPROC),
   localparam int IDX_W  = $clog2(NSETS),
   localparam int WAY_W  = $clog2(NWAYS),
   localparam int OVF_W  = $clog2(NOVF),
   localparam int SLOT_W = (WAY_W > OVF_W) ? WAY_W : OVF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [PID_W-1:0]  req_pid,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [1:0]        rsp_src,
   output logic [SLOT_W-1:0] rsp_slot,
   output logic [PID_W-1:0]  rsp_bank,
   input  logic              fill_ack,
   input  logic              own_clr_valid,
   input  logic [IDX_W-1:0]  own_clr_set
);
   localparam int TAG_W = ADDR_W - IDX_W;

   generate
      if (NPROC < 2)                  begin : g_bad_proc $error("setpin_llc: NPROC must be at least 2"); end
      if ((1 << IDX_W) != NSETS)      begin : g_bad_sets $error("setpin_llc: NSETS must be a power of two"); end
      if (ADDR_W <= IDX_W)            begin : g_bad_addr $error("setpin_llc: ADDR_W must exceed the index width"); end
   endgenerate

   state_e            state_q;
   logic [ADDR_W-1:0] q_addr;
   logic [PID_W-1:0]  q_pid;
   logic              to_ovf_q;

   logic              m_hit, m_owned, m_fill, m_upd;
   logic [WAY_W-1:0]  m_hitway, m_victim;
   logic [PID_W-1:0]  m_owner;

   logic [NPROC-1:0]  ovf_hit, bank_upd, bank_fill;
   logic [OVF_W-1:0]  ovf_idx [NPROC];
   logic [OVF_W-1:0]  ovf_vic [NPROC];
   logic              ovf_any, foreign, accept, looking, waiting;
   logic [PID_W-1:0]  ovf_sel;
   src_e              src;

   assign accept  = req_valid && req_ready;
   assign looking = (state_q == ST_LOOK);
   assign waiting = (state_q == ST_WAIT);

   setpin_main_array #(.SETS(NSETS), .WAYS(NWAYS), .TAG_W(TAG_W), .NPROC(NPROC)) u_main (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (q_addr[IDX_W-1:0]),
      .lk_tag    (q_addr[ADDR_W-1:IDX_W]),
      .lk_pid    (q_pid),
      .hit       (m_hit),
      .hit_way   (m_hitway),
      .victim    (m_victim),
      .owned     (m_owned),
      .owner     (m_owner),
      .upd_hit   (m_upd),
      .fill      (m_fill),
      .clr_valid (own_clr_valid),
      .clr_idx   (own_clr_set)
   );

   generate
      for (genvar p = 0; p < NPROC; p++) begin : g_bank
         assign bank_upd[p]  = looking && !m_hit && ovf_any && ovf_sel == PID_W'(p);
         assign bank_fill[p] = waiting && fill_ack && to_ovf_q && q_pid == PID_W'(p);
         setpin_ovf_bank #(.ENTRIES(NOVF), .AW(ADDR_W)) u_ovf (
            .clk     (clk),
            .rst_n   (rst_n),
            .lk_addr (q_addr),
            .hit     (ovf_hit[p]),
            .hit_idx (ovf_idx[p]),
            .upd_hit (bank_upd[p]),
            .fill    (bank_fill[p]),
            .victim  (ovf_vic[p])
         );
      end
   endgenerate

   always_comb begin
      ovf_any = 1'b0;
      ovf_sel = '0;
      for (int p = 0; p < NPROC; p++) begin
         if (ovf_hit[p] && !ovf_any) begin
            ovf_any = 1'b1;
            ovf_sel = PID_W'(p);
         end
      end
   end

   assign foreign = m_owned && (m_owner != q_pid);
   assign m_upd   = looking && m_hit;
   assign m_fill  = waiting && fill_ack && !to_ovf_q;

   always_comb begin
      rsp_hit  = m_hit | ovf_any;
      rsp_bank = q_pid;
      if (m_hit) begin
         src      = SRC_MAIN;
         rsp_slot = SLOT_W'(m_hitway);
      end else if (ovf_any) begin
         src      = SRC_OVF;
         rsp_slot = SLOT_W'(ovf_idx[ovf_sel]);
         rsp_bank = ovf_sel;
      end else if (foreign) begin
         src      = SRC_OVF;
         rsp_slot = SLOT_W'(ovf_vic[q_pid]);
      end else begin
         src      = SRC_MAIN;
         rsp_slot = SLOT_W'(m_victim);
      end
   end

   assign rsp_src   = src;
   assign rsp_valid = looking;
   assign req_ready = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         to_ovf_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) state_q <= ST_LOOK;
            ST_LOOK: begin
               to_ovf_q <= foreign;
               state_q  <= (m_hit || ovf_any) ? ST_IDLE : ST_WAIT;
            end
            ST_WAIT: if (fill_ack) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         q_addr <= req_addr;
         q_pid  <= req_pid;
      end
   end

   // R5: a line lives in at most one structure
   p_one_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
      looking |-> $onehot0({m_hit, ovf_hit}));

   // R2: the lookup result follows acceptance by one cycle
   p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid && !req_ready);
endmodule

// File: tb/setpin_llc_test.sv
module setpin_llc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_pid = '0;
   logic        rsp_valid, rsp_hit;
   logic [1:0]  rsp_src, rsp_slot, rsp_bank;
   logic        fill_ack = 1'b0;
   logic        own_clr_valid = 1'b0;
   logic [3:0]  own_clr_set = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   setpin_llc uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_pid(req_pid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_src(rsp_src), .rsp_slot(rsp_slot), .rsp_bank(rsp_bank), .fill_ack(fill_ack),
      .own_clr_valid(own_clr_valid), .own_clr_set(own_clr_set)
   );

   // {addr, pid, hit, src, slot, bank}; src 1 = main, 2 = overflow
   localparam int NV = 19;
   localparam logic [20:0] VEC [NV] = '{
      {12'h101, 2'd0, 1'b0, 2'd1, 2'd0, 2'd0},  // R1 R6 unowned set, claim
      {12'h101, 2'd0, 1'b1, 2'd1, 2'd0, 2'd0},  // R3
      {12'h101, 2'd1, 1'b1, 2'd1, 2'd0, 2'd1},  // R3 non-owner hits main
      {12'h201, 2'd1, 1'b0, 2'd2, 2'd0, 2'd1},  // R8 redirected to own overflow
      {12'h201, 2'd2, 1'b1, 2'd2, 2'd0, 2'd1},  // R4 hit in another's overflow
      {12'h301, 2'd0, 1'b0, 2'd1, 2'd1, 2'd0},  // R7
      {12'h401, 2'd0, 1'b0, 2'd1, 2'd2, 2'd0},  // R7
      {12'h501, 2'd0, 1'b0, 2'd1, 2'd3, 2'd0},  // R7
      {12'h601, 2'd0, 1'b0, 2'd1, 2'd0, 2'd0},  // R7 evicts oldest way 0
      {12'h101, 2'd3, 1'b0, 2'd2, 2'd0, 2'd3},  // R5 evicted line misses
      {12'h701, 2'd1, 1'b0, 2'd2, 2'd1, 2'd1},  // R9
      {12'h801, 2'd1, 1'b0, 2'd2, 2'd2, 2'd1},  // R9
      {12'h901, 2'd1, 1'b0, 2'd2, 2'd3, 2'd1},  // R9
      {12'hA01, 2'd1, 1'b0, 2'd2, 2'd0, 2'd1},  // R9 overflow LRU eviction
      {12'h201, 2'd2, 1'b0, 2'd2, 2'd0, 2'd2},  // R5
      {12'h701, 2'd1, 1'b1, 2'd2, 2'd1, 2'd1},  // R4
      {12'h0F2, 2'd2, 1'b0, 2'd1, 2'd0, 2'd2},  // R6 second set
      {12'h1F2, 2'd3, 1'b0, 2'd2, 2'd1, 2'd3},  // R8
      {12'h301, 2'd0, 1'b1, 2'd1, 2'd1, 2'd0}   // R8 main set left intact
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic access(input logic [11:0] a, input logic [1:0] pid, input logic e_hit,
                         input logic [1:0] e_src, input logic [1:0] e_slot, input logic [1:0] e_bank,
                         input string req);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_pid = pid;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid && !req_ready, "R2 response timing", {rsp_valid, req_ready}, 2'b10);
      chk({rsp_hit, rsp_src, rsp_slot, rsp_bank} == {e_hit, e_src, e_slot, e_bank}, req,
          {rsp_hit, rsp_src, rsp_slot, rsp_bank}, {e_hit, e_src, e_slot, e_bank});
      if (!e_hit) begin
         @(negedge clk);
         chk(!req_ready && !rsp_valid, "R2 waiting for fill", {rsp_valid, req_ready}, 2'b00);
         fill_ack = 1'b1;
         @(negedge clk);
         fill_ack = 1'b0;
         chk(req_ready, "R2 ready after fill", req_ready, 1);
      end
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid, "R1 reset state", {req_ready, rsp_valid}, 2'b10);

      for (int i = 0; i < NV; i++) begin
         access(VEC[i][20:9], VEC[i][8:7], VEC[i][6], VEC[i][5:4], VEC[i][3:2], VEC[i][1:0],
                $sformatf("table row %0d", i));
      end

      // R10: clearing the owner of set 2 lets another processor claim it
      @(negedge clk);
      own_clr_valid = 1'b1; own_clr_set = 4'd2;
      @(negedge clk);
      own_clr_valid = 1'b0;
      access(12'h2F2, 2'd3, 1'b0, 2'd1, 2'd1, 2'd3, "R10 claim after clear");
      access(12'h3F2, 2'd2, 1'b0, 2'd2, 2'd1, 2'd2, "R10 new owner pins set");
      access(12'h0F2, 2'd3, 1'b1, 2'd1, 2'd0, 2'd3, "R10 lines kept valid");

      // R11: stray fill_ack while idle does nothing
      @(negedge clk);
      fill_ack = 1'b1;
      @(negedge clk);
      fill_ack = 1'b0;
      chk(req_ready && !rsp_valid, "R11 idle fill_ack ignored", {req_ready, rsp_valid}, 2'b10);
      access(12'h3F2, 2'd2, 1'b1, 2'd2, 2'd1, 2'd2, "R11 state unchanged");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule